// File: doc/BRIEF.md
# Complementary Three-Phase PWM Generator

This block drives three pairs of complementary PWM outputs from a symmetric triangle carrier. Each pair has a positive-phase pin and a negative-phase pin. Two up/down counters run in lockstep. Counter B sweeps from 0 up to the half period and back. Counter A carries the same waveform raised by the dead-time value. The positive pin of a phase turns on from counter B and the negative pin turns off from counter A. The offset between the two counters opens a gap around every switching instant, so the two pins of a pair are never active together.

Software sets the block up through a write-only register port while the `run` input is low. Duty values and the half period each have a shadow register, and these shadows can be written at any time. Their contents move into the active registers only at the carrier's crest or trough, so a carrier cycle never mixes old and new settings. A control word holds the following:
- the active level of the positive pins and of the negative pins;
- one enable bit per pin;
- the enable for a toggle output that flips once per carrier cycle.

When `run` is raised, both counters leave their preload values on the same clock edge.

Top module: `cpwm_triphase`

## Requirements
- R1: After reset, all six PWM pins and `cyc_tgl` are 0. At reset the control word has both active levels set to high, every pin enable cleared, and the toggle disabled.
- R2: Register addresses are as follows:
  - 0: dead time
  - 1: active half period
  - 2: half-period shadow
  - 3: counter-A upper limit
  - 4..6: active duty of phases 0..2
  - 8..10: duty shadow of phases 0..2
  - 12: control word, with bit0 the positive active level (1 = active high), bit1 the negative active level, bit2 the toggle enable, bits5:3 the positive-pin enables of phases 0..2, and bits8:6 the negative-pin enables of phases 0..2

  Writes to addresses 0, 1, 3, 4..6 and 12 are ignored while `run` is high. Writes to the shadow addresses are accepted at any time.
- R3: While `run` is low, counter B holds 0 and counter A holds the dead time. On the first rising edge with `run` high, both counters step by one. From then on, each counter changes by exactly one per cycle. Counter B turns at the half period and at 0. Counter A turns at the limit and at the dead time. The limit must be programmed to half period plus dead time.
- R4: For a duty D with 0 < D < half period:
  - the positive phase is on when counter B ≥ D;
  - the negative phase is on when counter A ≤ D;
  - the two are never on together.

  Over one full carrier period of 2·H cycles, where H is the half period, the positive pin is active for 2(H−D)+1 cycles. The negative pin is active for 2(D−dt)+1 cycles when D ≥ dt and for 0 cycles otherwise. A dead time of 1 therefore gives no gap. Pins are registered and show the phase state of the counter value from the previous cycle.
- R5: A duty of 0 holds the positive pin active and the negative pin inactive. A duty at or above the half period holds the positive pin inactive and the negative pin active.
- R6: At counter B's crest or trough, the duty shadows move into the active duties and the half-period shadow moves into the active half period. At the same time the limit is moved by the same amount as the half period, which keeps its offset.
- R7: A pin is driven to its group's active level when its phase is on and to the opposite level otherwise.
- R8: A pin whose enable bit is 0 is held at its inactive level.
- R9: While `run` is low, all six pins sit at their inactive levels.
- R10: When the toggle is enabled, `cyc_tgl` flips once at each trough of counter B, which is once every 2·H cycles. When the toggle is disabled, `cyc_tgl` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Count enable; low stops and preloads both counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| out_p | output | 3 | Positive-phase PWM pins, phases 0..2 |
| out_n | output | 3 | Negative-phase PWM pins, phases 0..2 |
| cyc_tgl | output | 1 | Carrier-cycle toggle |

## Verification
The hardest situation to reach from the ports is a shadow update that takes effect while the counters are running. This covers both a new duty and a new half period, which also moves the limit and changes the period of the toggle output. To get there, the stimulus writes the shadows in the middle of a run and then waits past the next crest or trough. It then measures a window exactly one carrier period long. Because the pulse widths are counted over a whole period rather than at fixed edges, the result does not depend on where in the triangle the write happened. A second directed run writes the protected registers while counting, and shows through unchanged pulse widths that those writes were ignored.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int W      = 16;
  localparam int AW     = 4;
  localparam int NPH    = 3;
  localparam int CTRL_W = 3 + 2 * NPH;

  localparam int A_DEAD     = 0;
  localparam int A_HALF     = 1;
  localparam int A_HALF_BUF = 2;
  localparam int A_LIMIT    = 3;
  localparam int A_DUTY0    = 4;
  localparam int A_DUTYB0   = 8;
  localparam int A_CTRL     = 12;

  typedef logic [W-1:0] cnt_t;

  typedef struct packed {
    logic [NPH-1:0] en_n;
    logic [NPH-1:0] en_p;
    logic           tgl_en;
    logic           lvl_n;
    logic           lvl_p;
  } ctrl_t;

  // direction after this step: turn down at hi, turn up at lo
  function automatic logic next_up(cnt_t c, logic up, cnt_t lo, cnt_t hi);
    if (up) return !(c >= hi);
    else    return (c <= lo);
  endfunction

  // {pos_on, neg_on} for one phase
  function automatic logic [1:0] phase_on(cnt_t cb, cnt_t ca, cnt_t duty, cnt_t half);
    if (duty == '0)        return 2'b10;
    else if (duty >= half) return 2'b01;
    else                   return {cb >= duty, ca <= duty};
  endfunction

  function automatic logic pin_level(logic on, logic en, logic lvl);
    return (on && en) ? lvl : !lvl;
  endfunction

  // keep the limit's distance from the half period when the period changes
  function automatic cnt_t shift_limit(cnt_t lim, cnt_t old_half, cnt_t new_half);
    return new_half + (lim - old_half);
  endfunction
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  cnt_t preload,
  input  cnt_t lo,
  input  cnt_t hi,
  output cnt_t cnt,
  output logic turn_hi,
  output logic turn_lo
);
  logic up;
  logic nu;

  assign nu      = next_up(cnt, up, lo, hi);
  assign turn_hi = run && up && (cnt >= hi);
  assign turn_lo = run && !up && (cnt <= lo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (!run) begin
      cnt <= preload;
      up  <= 1'b1;
    end else begin
      up  <= nu;
      cnt <= nu ? cnt + cnt_t'(1) : cnt - cnt_t'(1);
    end
  end

  // R3: a running counter moves by exactly one each cycle
  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run)) |->
      ((cnt - $past(cnt) == cnt_t'(1)) || ($past(cnt) - cnt == cnt_t'(1))));
endmodule

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [W-1:0]         wr_data,
  input  logic                 xfer,
  output cnt_t                 dead,
  output cnt_t                 half,
  output cnt_t                 limit,
  output cnt_t [NPH-1:0]       duty,
  output ctrl_t                ctrl
);
  cnt_t            half_buf;
  cnt_t [NPH-1:0]  duty_buf;
  logic            cfg_ok;
  logic            cfg_wr;

  assign cfg_ok = !run;
  assign cfg_wr = wr_en && cfg_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dead     <= cnt_t'(1);
      half     <= cnt_t'(2);
      half_buf <= cnt_t'(2);
      limit    <= cnt_t'(3);
      duty     <= '0;
      duty_buf <= '0;
      ctrl     <= '{en_n: '0, en_p: '0, tgl_en: 1'b0, lvl_n: 1'b1, lvl_p: 1'b1};
    end else begin
      if (cfg_wr && wr_addr == AW'(A_DEAD))  dead  <= wr_data;
      if (cfg_wr && wr_addr == AW'(A_HALF))  half  <= wr_data;
      if (cfg_wr && wr_addr == AW'(A_LIMIT)) limit <= wr_data;
      if (cfg_wr && wr_addr == AW'(A_CTRL))  ctrl  <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_en && wr_addr == AW'(A_HALF_BUF)) half_buf <= wr_data;
      for (int i = 0; i < NPH; i++) begin
        if (cfg_wr && wr_addr == AW'(A_DUTY0 + i)) duty[i]     <= wr_data;
        if (wr_en && wr_addr == AW'(A_DUTYB0 + i)) duty_buf[i] <= wr_data;
      end
      if (xfer) begin
        half  <= half_buf;
        limit <= shift_limit(limit, half, half_buf);
        duty  <= duty_buf;
      end
    end
  end

  // R2: protected settings do not move while counting
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run)) |-> (dead == $past(dead) && ctrl == $past(ctrl)));

  // R6: active duties change only at a turning point or while stopped
  p_duty_buffered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run) && !$past(xfer)) |-> (duty == $past(duty)));
endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase
  import cpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  cnt_t cb,
  input  cnt_t ca,
  input  cnt_t duty,
  input  cnt_t half,
  input  logic lvl_p,
  input  logic lvl_n,
  input  logic en_p,
  input  logic en_n,
  output logic pin_p,
  output logic pin_n
);
  logic [1:0] on;
  logic       pos_on;
  logic       neg_on;

  assign on     = phase_on(cb, ca, duty, half);
  assign pos_on = on[1];
  assign neg_on = on[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_p <= 1'b0;
      pin_n <= 1'b0;
    end else begin
      pin_p <= run ? pin_level(pos_on, en_p, lvl_p) : !lvl_p;
      pin_n <= run ? pin_level(neg_on, en_n, lvl_n) : !lvl_n;
    end
  end

  // R4: phase decisions never overlap
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_on && neg_on));

  // R4: the registered pins of a pair are never both at their active level
  p_pair_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !((pin_p == $past(lvl_p)) && (pin_n == $past(lvl_n))));

  // R8: a disabled pin stays inactive
  p_disabled_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en_p)) |-> (pin_p == !$past(lvl_p)));
endmodule

// File: rtl/cpwm_triphase.sv
module cpwm_triphase
  import cpwm_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  output logic [NPH-1:0] out_p,
  output logic [NPH-1:0] out_n,
  output logic           cyc_tgl
);
  cnt_t           dead, half, limit;
  cnt_t [NPH-1:0] duty;
  ctrl_t          ctrl;
  cnt_t           cnt_a, cnt_b;
  logic           crest_b, trough_b, crest_a, trough_a;
  logic           xfer_evt;

  assign xfer_evt = crest_b || trough_b;

  cpwm_regs u_regs (
    .clk, .rst_n, .run, .wr_en, .wr_addr, .wr_data,
    .xfer(xfer_evt), .dead, .half, .limit, .duty, .ctrl
  );

  cpwm_counter u_cnt_b (
    .clk, .rst_n, .run, .preload('0), .lo('0), .hi(half),
    .cnt(cnt_b), .turn_hi(crest_b), .turn_lo(trough_b)
  );

  cpwm_counter u_cnt_a (
    .clk, .rst_n, .run, .preload(dead), .lo(dead), .hi(limit),
    .cnt(cnt_a), .turn_hi(crest_a), .turn_lo(trough_a)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    cpwm_phase u_phase (
      .clk, .rst_n, .run,
      .cb(cnt_b), .ca(cnt_a), .duty(duty[g]), .half,
      .lvl_p(ctrl.lvl_p), .lvl_n(ctrl.lvl_n),
      .en_p(ctrl.en_p[g]), .en_n(ctrl.en_n[g]),
      .pin_p(out_p[g]), .pin_n(out_n[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        cyc_tgl <= 1'b0;
    else if (ctrl.tgl_en && trough_b)  cyc_tgl <= !cyc_tgl;
  end

  // R3: stopped counters sit at their preload values
  p_start_preload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(run)) |-> (cnt_b == '0 && cnt_a == $past(dead)));

  // R3: with a correctly programmed limit both counters turn together
  p_turns_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (crest_a == crest_b && trough_a == trough_b));

  // R9: all pins idle while stopped
  p_stopped_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(run)) |->
      (out_p == {NPH{!$past(ctrl.lvl_p)}} && out_n == {NPH{!$past(ctrl.lvl_n)}}));

  // R10: toggle output holds when disabled
  p_tgl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ctrl.tgl_en)) |-> (cyc_tgl == $past(cyc_tgl)));
endmodule

// File: tb/test_cpwm_triphase.sv
module test_cpwm_triphase;
  localparam int CLK_NS = 10;
  localparam int NV = 8;
  // {dead, half, duty, expected positive cycles, expected negative cycles}
  localparam int TBL [NV][5] = '{
    '{3, 10, 5, 11, 5},
    '{1, 10, 5, 11, 9},
    '{3, 10, 0, 20, 0},
    '{3, 10, 10, 0, 20},
    '{2, 10, 9, 3, 15},
    '{4, 10, 1, 19, 0},
    '{2, 6, 3, 7, 3},
    '{1, 6, 15, 0, 12}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  out_p, out_n;
  logic        cyc_tgl;

  int checks = 0;
  int fails = 0;
  int pcnt [3];
  int ncnt [3];
  int ovl, tgc;
  logic lp = 1'b1, ln = 1'b1;

  cpwm_triphase i_cpwm_triphase (
    .clk, .rst_n, .run, .wr_en, .wr_addr, .wr_data, .out_p, .out_n, .cyc_tgl
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // stop, program everything, leave run low at a negedge
  task automatic setup(input int dt, input int h, input int d, input int ctl);
    @(negedge clk);
    run = 1'b0;
    repeat (2) @(negedge clk);
    wr(0, dt); wr(1, h); wr(2, h); wr(3, h + dt);
    for (int i = 0; i < 3; i++) begin
      wr(4 + i, d); wr(8 + i, d);
    end
    wr(12, ctl);
    lp = ctl[0]; ln = ctl[1];
    repeat (2) @(negedge clk);
  endtask

  task automatic measure(input int n);
    logic prev;
    for (int i = 0; i < 3; i++) begin pcnt[i] = 0; ncnt[i] = 0; end
    ovl = 0; tgc = 0;
    prev = cyc_tgl;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        if (out_p[i] == lp) pcnt[i]++;
        if (out_n[i] == ln) ncnt[i]++;
        if (out_p[i] == lp && out_n[i] == ln) ovl++;
      end
      if (cyc_tgl != prev) tgc++;
      prev = cyc_tgl;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out_p", out_p, 0);
    chk("R1 out_n", out_n, 0);
    chk("R1 cyc_tgl", cyc_tgl, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: pulse widths over one carrier period (R4, R5, R9)
    for (int v = 0; v < NV; v++) begin
      setup(TBL[v][0], TBL[v][1], TBL[v][2], 'h1FF);
      chk("R9 idle p", out_p, 0);
      chk("R9 idle n", out_n, 0);
      run = 1'b1;
      repeat (2) @(negedge clk);
      measure(2 * TBL[v][1]);
      for (int i = 0; i < 3; i++) begin
        chk("R4/R5 positive width", pcnt[i], TBL[v][3]);
        chk("R4/R5 negative width", ncnt[i], TBL[v][4]);
      end
      chk("R4 no overlap", ovl, 0);
    end

    // R3: start timing from preload
    setup(3, 10, 5, 'h1FF);
    run = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 3) chk("R3 neg on at step 3", out_n[0], 1);
      if (k == 4) chk("R3 neg off at step 4", out_n[0], 0);
      if (k == 5) chk("R3 pos off at step 5", out_p[0], 0);
      if (k == 6) chk("R3 pos on at step 6", out_p[0], 1);
    end

    // R2: protected writes while running are ignored
    wr(4, 8); wr(0, 1); wr(12, 'h003);
    repeat (25) @(negedge clk);
    measure(20);
    chk("R2 duty write ignored pos", pcnt[0], 11);
    chk("R2 dead write ignored neg", ncnt[0], 5);
    chk("R2 ctrl write ignored p1", pcnt[1], 11);

    // R10: toggle every carrier period
    measure(80);
    chk("R10 toggles in 80 cycles", tgc, 4);

    // R6: duty shadow update while running
    wr(8, 8);
    repeat (24) @(negedge clk);
    measure(20);
    chk("R6 new duty pos", pcnt[0], 5);
    chk("R6 new duty neg", ncnt[0], 11);
    chk("R6 other phase unchanged", pcnt[1], 11);

    // R6: half-period shadow update while running
    wr(2, 8);
    repeat (30) @(negedge clk);
    measure(16);
    chk("R6 half change clamps phase0 pos", pcnt[0], 0);
    chk("R6 half change clamps phase0 neg", ncnt[0], 16);
    chk("R6 half change phase1 pos", pcnt[1], 7);
    chk("R6 half change phase1 neg", ncnt[1], 5);
    chk("R6 no overlap", ovl, 0);
    measure(64);
    chk("R6 toggle period follows half", tgc, 4);

    // R7: active-low polarity
    setup(3, 10, 5, 'h1FC);
    chk("R9 idle high p", out_p, 7);
    chk("R9 idle high n", out_n, 7);
    run = 1'b1;
    repeat (2) @(negedge clk);
    measure(20);
    chk("R7 low-active pos", pcnt[0], 11);
    chk("R7 low-active neg", ncnt[0], 5);

    // R8: individual enables
    setup(3, 10, 5, 'h0EF);
    run = 1'b1;
    repeat (2) @(negedge clk);
    measure(20);
    chk("R8 disabled p1", pcnt[1], 0);
    chk("R8 disabled n2", ncnt[2], 0);
    chk("R8 enabled p0", pcnt[0], 11);
    chk("R8 enabled n0", ncnt[0], 5);

    // R10: toggle disabled holds
    setup(3, 10, 5, 'h1FB);
    run = 1'b1;
    repeat (2) @(negedge clk);
    measure(64);
    chk("R10 disabled toggle holds", tgc, 0);

    finish_run();
  end
endmodule